// File: doc/BRIEF.md
# Closed-Page SDRAM Access Sequencer

This block is the cycle sequencer that sits between a memory controller's front end and its command encoder. Once memory initialisation has finished, it decides each idle clock whether to run a refresh or an access. It then steps through a fixed chain of states. The command encoder turns the published state code into the pins on the memory bus, and the data path uses the two phase enables to move burst data.

Each access opens its row with ACTIVE. After the row-to-column wait it issues a read or a write that carries the auto-precharge flag, so the row closes by itself. This makes every read, and every write, take the same number of clocks wherever it lands in the address space.

Refresh uses a request/acknowledge handshake. The acknowledge covers the whole refresh. A request that is still high when the sequencer gets back to idle starts a further refresh. Burst length, CAS latency, the row-to-column wait, the write recovery and precharge times and the refresh wait are all parameters.

Top module: `sdr_access_seq`

## Requirements
- R1: While reset is held, the state code is 0 (idle), and the refresh acknowledge, both phase enables and the auto-precharge flag are all low.
- R2: While init-done is low the sequencer remains idle, whatever the address strobe and refresh request do.
- R3: Sampling the refresh request high in an idle clock always enters the refresh state on the next edge, even when the address strobe is also low. The acknowledge is high for one refresh-command clock followed by RFC_WAIT wait clocks (3 by default), and the sequencer then returns to idle.
- R4: An address strobe held low during a refresh is ignored. If the strobe is high when the sequencer is idle again, no access follows.
- R5: A refresh request still held high in the idle clock after a refresh starts another complete refresh.
- R6: An access is accepted when the strobe is low and the request low in an idle clock. It then passes through ACTIVE and RCD_WAIT row-to-column wait clocks (1 by default), then a single command clock. In that command clock the auto-precharge flag is high.
- R7: The direction is taken only from the read/not-write input at the edge that leaves the row-to-column wait, with 1 meaning read. Values before or after that edge have no effect.
- R8: A read runs read command, then CAS_LAT latency clocks, then BURST_LEN clocks with the read-phase enable high, then idle. With CAS latency 2 and burst 4 the cycle occupies 10 clocks counting the accepting idle clock.
- R9: A write runs write command, then BURST_LEN clocks with the write-phase enable high, then TWR_CLK+TRP_CLK-1 recovery clocks, then idle. With the defaults the cycle occupies 9 clocks counting the accepting idle clock.
- R10: State codes are: idle 0, refresh command 1, refresh wait 2, activate 3, row-to-column wait 4, read command 5, latency wait 6, read data 7, write command 8, write data 9, write recovery 10. The acknowledge is high exactly in codes 1 and 2, the read-phase enable in 7, the write-phase enable in 9, and the auto-precharge flag in 5 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done_i | input | 1 | High once memory initialisation is complete |
| ads_n_i | input | 1 | Active-low access strobe |
| rd_wrn_i | input | 1 | Direction: 1 read, 0 write |
| ref_req_i | input | 1 | Refresh request, held until acknowledged |
| state_o | output | 4 | State code for the command encoder |
| ref_ack_o | output | 1 | Refresh acknowledge |
| rd_phase_o | output | 1 | Read data phase enable |
| wr_phase_o | output | 1 | Write data phase enable |
| autopre_o | output | 1 | Auto-precharge flag for the column command |

## Verification
The hardest situation to reach from the ports is one where two inputs are sampled on the same edge and only one of them may win. This happens when a refresh request and an access strobe arrive together. It also happens when the direction input changes around the single edge that latches it.

The stimulus holds the strobe low across an entire refresh to show that it is ignored. It keeps the request high past the return to idle to force a second refresh. In a read, it sets the direction wrong at acceptance, corrects it only one clock before the latching edge, and flips it again right after. The scoreboard compares every state clock against the sequence that the requirements predict.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

   typedef enum logic [3:0] {
      S_IDLE  = 4'd0,
      S_AREF  = 4'd1,
      S_RFCW  = 4'd2,
      S_ACTV  = 4'd3,
      S_RCDW  = 4'd4,
      S_RDCMD = 4'd5,
      S_CLW   = 4'd6,
      S_RDAT  = 4'd7,
      S_WRCMD = 4'd8,
      S_WDAT  = 4'd9,
      S_DALW  = 4'd10
   } seq_state_t;

endpackage

// File: rtl/sdr_wait_cnt.sv
module sdr_wait_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= val_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   // the counter saturates at zero and never wraps (supports R3, R8, R9)
   assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/sdr_phase_dec.sv
module sdr_phase_dec
   import sdr_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  seq_state_t st_i,
   output logic       ref_ack_o,
   output logic       rd_phase_o,
   output logic       wr_phase_o,
   output logic       autopre_o
);

   always_comb begin
      ref_ack_o  = (st_i == S_AREF) || (st_i == S_RFCW);
      rd_phase_o = (st_i == S_RDAT);
      wr_phase_o = (st_i == S_WDAT);
      autopre_o  = (st_i == S_RDCMD) || (st_i == S_WRCMD);
   end

   // at most one of the decoded strobes is active at a time (R10)
   assert_excl_strobes_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ref_ack_o, rd_phase_o, wr_phase_o, autopre_o}));

   // no data moves while a refresh is acknowledged (R4)
   assert_ack_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ref_ack_o |-> (!rd_phase_o && !wr_phase_o));

endmodule

// File: rtl/sdr_access_seq.sv
module sdr_access_seq
   import sdr_seq_pkg::*;
#(
   parameter int BURST_LEN = 4,
   parameter int CAS_LAT   = 2,
   parameter int RCD_WAIT  = 1,
   parameter int TWR_CLK   = 1,
   parameter int TRP_CLK   = 1,
   parameter int RFC_WAIT  = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       init_done_i,
   input  logic       ads_n_i,
   input  logic       rd_wrn_i,
   input  logic       ref_req_i,
   output logic [3:0] state_o,
   output logic       ref_ack_o,
   output logic       rd_phase_o,
   output logic       wr_phase_o,
   output logic       autopre_o
);

   // the last write-data clock already counts toward recovery
   localparam int DAL_WAIT = TWR_CLK + TRP_CLK - 1;
   localparam int MAX_A    = (BURST_LEN > CAS_LAT) ? BURST_LEN : CAS_LAT;
   localparam int MAX_B    = (RCD_WAIT > DAL_WAIT) ? RCD_WAIT : DAL_WAIT;
   localparam int MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int MAXV     = (MAX_C > RFC_WAIT) ? MAX_C : RFC_WAIT;
   localparam int CW       = $clog2(MAXV + 1);

   localparam int RCD_LD = (RCD_WAIT > 0) ? RCD_WAIT - 1 : 0;
   localparam int CL_LD  = (CAS_LAT  > 0) ? CAS_LAT  - 1 : 0;
   localparam int BL_LD  = BURST_LEN - 1;
   localparam int DAL_LD = (DAL_WAIT > 0) ? DAL_WAIT - 1 : 0;
   localparam int RFC_LD = (RFC_WAIT > 0) ? RFC_WAIT - 1 : 0;

   generate
      if (!(BURST_LEN == 2 || BURST_LEN == 4 || BURST_LEN == 8)) begin : g_bad_bl
         $error("sdr_access_seq: BURST_LEN must be 2, 4 or 8");
      end
      if (CAS_LAT < 0 || RCD_WAIT < 0 || RFC_WAIT < 0) begin : g_bad_wait
         $error("sdr_access_seq: wait counts must not be negative");
      end
      if (TWR_CLK < 1 || TRP_CLK < 1) begin : g_bad_dal
         $error("sdr_access_seq: TWR_CLK and TRP_CLK must be at least 1");
      end
   endgenerate

   seq_state_t      st_q, st_d;
   logic            ld;
   logic [CW-1:0]   ld_val;
   logic            cnt_zero;
   seq_state_t      col_st;

   // direction latched on the edge that leaves the row-to-column wait
   assign col_st = rd_wrn_i ? S_RDCMD : S_WRCMD;

   always_comb begin
      st_d   = st_q;
      ld     = 1'b0;
      ld_val = '0;
      unique case (st_q)
         S_IDLE: begin
            if (init_done_i) begin
               if (ref_req_i)
                  st_d = S_AREF;
               else if (!ads_n_i)
                  st_d = S_ACTV;
            end
         end
         S_AREF: begin
            if (RFC_WAIT != 0) begin
               st_d = S_RFCW; ld = 1'b1; ld_val = CW'(RFC_LD);
            end else
               st_d = S_IDLE;
         end
         S_RFCW:  if (cnt_zero) st_d = S_IDLE;
         S_ACTV: begin
            if (RCD_WAIT != 0) begin
               st_d = S_RCDW; ld = 1'b1; ld_val = CW'(RCD_LD);
            end else
               st_d = col_st;
         end
         S_RCDW:  if (cnt_zero) st_d = col_st;
         S_RDCMD: begin
            ld = 1'b1;
            if (CAS_LAT != 0) begin
               st_d = S_CLW;  ld_val = CW'(CL_LD);
            end else begin
               st_d = S_RDAT; ld_val = CW'(BL_LD);
            end
         end
         S_CLW: begin
            if (cnt_zero) begin
               st_d = S_RDAT; ld = 1'b1; ld_val = CW'(BL_LD);
            end
         end
         S_RDAT:  if (cnt_zero) st_d = S_IDLE;
         S_WRCMD: begin
            st_d = S_WDAT; ld = 1'b1; ld_val = CW'(BL_LD);
         end
         S_WDAT: begin
            if (cnt_zero) begin
               if (DAL_WAIT != 0) begin
                  st_d = S_DALW; ld = 1'b1; ld_val = CW'(DAL_LD);
               end else
                  st_d = S_IDLE;
            end
         end
         S_DALW:  if (cnt_zero) st_d = S_IDLE;
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_q <= S_IDLE;
      else
         st_q <= st_d;
   end

   sdr_wait_cnt #(.W(CW)) u_wait (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (ld),
      .val_i  (ld_val),
      .zero_o (cnt_zero)
   );

   sdr_phase_dec u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .st_i       (st_q),
      .ref_ack_o  (ref_ack_o),
      .rd_phase_o (rd_phase_o),
      .wr_phase_o (wr_phase_o),
      .autopre_o  (autopre_o)
   );

   assign state_o = st_q;

   assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_IDLE && !init_done_i) |=> (st_q == S_IDLE));

   assert_ref_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_IDLE && init_done_i && ref_req_i) |=> (st_q == S_AREF));

   assert_ref_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_RFCW && cnt_zero) |=> (st_q == S_IDLE));

   assert_act_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_ACTV) |=> (st_q inside {S_RCDW, S_RDCMD, S_WRCMD}));

   assert_dir_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_RCDW && cnt_zero && rd_wrn_i) |=> (st_q == S_RDCMD));

   assert_dir_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_RCDW && cnt_zero && !rd_wrn_i) |=> (st_q == S_WRCMD));

   assert_read_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_RDCMD) |=> (st_q inside {S_CLW, S_RDAT}));

   assert_write_recover_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_WDAT && cnt_zero) |=> (st_q inside {S_DALW, S_IDLE}));

endmodule

// File: tb/tb_sdr_access_seq.sv
`timescale 1ns/100ps
module tb_sdr_access_seq;

   localparam logic [3:0] C_IDLE = 4'd0, C_AREF = 4'd1, C_RFCW = 4'd2,
                          C_ACTV = 4'd3, C_RCDW = 4'd4, C_RDCMD = 4'd5,
                          C_CLW  = 4'd6, C_RDAT = 4'd7, C_WRCMD = 4'd8,
                          C_WDAT = 4'd9, C_DALW = 4'd10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic init_done = 1'b0;
   logic ads_n = 1'b1;
   logic rd_wrn = 1'b0;
   logic ref_req = 1'b0;
   logic [3:0] state;
   logic ref_ack, rd_phase, wr_phase, autopre;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit mon_on = 1'b0;
   string idle_tag = "R2";

   logic [3:0] exp_q[$];
   string      tag_q[$];

   always #2.5 clk = ~clk;

   sdr_access_seq dut (
      .clk(clk), .rst_n(rst_n), .init_done_i(init_done), .ads_n_i(ads_n),
      .rd_wrn_i(rd_wrn), .ref_req_i(ref_req), .state_o(state),
      .ref_ack_o(ref_ack), .rd_phase_o(rd_phase), .wr_phase_o(wr_phase),
      .autopre_o(autopre)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   task automatic push(input logic [3:0] s, input string t);
      exp_q.push_back(s);
      tag_q.push_back(t);
   endtask

   // monitor: compares each clock against the scoreboard queue
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (mon_on) begin
            logic [3:0] e;
            string t;
            if (exp_q.size() > 0) begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
            end else begin
               e = C_IDLE;
               t = idle_tag;
            end
            check(state == e, t, "state", state, e);
            check(ref_ack == (e == C_AREF || e == C_RFCW), {t, "/R10"}, "ack",
                  ref_ack, (e == C_AREF || e == C_RFCW));
            check(rd_phase == (e == C_RDAT), {t, "/R10"}, "rd_phase",
                  rd_phase, (e == C_RDAT));
            check(wr_phase == (e == C_WDAT), {t, "/R10"}, "wr_phase",
                  wr_phase, (e == C_WDAT));
            check(autopre == (e == C_RDCMD || e == C_WRCMD), {t, "/R6"}, "autopre",
                  autopre, (e == C_RDCMD || e == C_WRCMD));
         end
      end
   end

   task automatic drain();
      while (exp_q.size() > 0) @(negedge clk);
      @(negedge clk);
   endtask

   // access driver; flip=1 sets a wrong direction except at the latching edge (R7)
   task automatic run_access(input logic dir, input bit flip, input string tag);
      @(negedge clk);
      ads_n  = 1'b0;
      rd_wrn = flip ? ~dir : dir;
      push(C_ACTV, tag);
      push(C_RCDW, tag);
      if (dir) begin
         push(C_RDCMD, tag);
         for (int i = 0; i < 2; i++) push(C_CLW, tag);
         for (int i = 0; i < 4; i++) push(C_RDAT, tag);
      end else begin
         push(C_WRCMD, tag);
         for (int i = 0; i < 4; i++) push(C_WDAT, tag);
         push(C_DALW, tag);
      end
      push(C_IDLE, tag);
      @(negedge clk); ads_n = 1'b1;
      @(negedge clk); rd_wrn = dir;
      @(negedge clk); if (flip) rd_wrn = ~dir;
      drain();
   endtask

   // refresh driver: times = refreshes expected, drop_k = negedge to drop request
   task automatic run_refresh(input int times, input int drop_k, input bit ads_low,
                              input string tag);
      @(negedge clk);
      ref_req = 1'b1;
      ads_n   = ads_low ? 1'b0 : 1'b1;
      for (int n = 0; n < times; n++) begin
         push(C_AREF, tag);
         for (int i = 0; i < 3; i++) push(C_RFCW, tag);
         push(C_IDLE, tag);
      end
      for (int k = 1; k <= 20; k++) begin
         @(negedge clk);
         if (k == drop_k) ref_req = 1'b0;
         if (k == 4) ads_n = 1'b1;
      end
      drain();
   endtask

   // watchdog
   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      // R1: reset state
      ads_n = 1'b0;
      ref_req = 1'b1;
      repeat (3) @(negedge clk);
      check(state == C_IDLE, "R1", "state", state, 0);
      check({ref_ack, rd_phase, wr_phase, autopre} == 4'b0, "R1", "strobes",
            {ref_ack, rd_phase, wr_phase, autopre}, 0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      // R2: init low, requests present, stays idle
      idle_tag = "R2";
      repeat (6) @(negedge clk);
      ads_n = 1'b1;
      ref_req = 1'b0;
      init_done = 1'b1;
      idle_tag = "R6";
      repeat (2) @(negedge clk);
      // R8: plain read, 10-clock cycle
      run_access(1'b1, 1'b0, "R8");
      // R9: plain write, 9-clock cycle
      run_access(1'b0, 1'b0, "R9");
      // R7: direction only at the latching edge
      run_access(1'b1, 1'b1, "R7");
      run_access(1'b0, 1'b1, "R7");
      // R3: single refresh, request dropped once acknowledge is seen
      idle_tag = "R3";
      run_refresh(1, 1, 1'b0, "R3");
      // R4: strobe low together with request, held through refresh
      idle_tag = "R4";
      run_refresh(1, 1, 1'b1, "R4");
      // R5: request held past return to idle gives a second refresh
      idle_tag = "R5";
      run_refresh(2, 6, 1'b0, "R5");
      // R6: access after refreshes still works
      idle_tag = "R6";
      run_access(1'b1, 1'b0, "R6");
      repeat (3) @(negedge clk);
      mon_on = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule